// File: doc/BRIEF.md
# Effective Address Generator

This block forms the 16-bit effective address of a memory operand for an 8-bit CPU core that has a 64 KB address space. The instruction decoder presents a mode code, an indirection flag, the operand bytes already taken from the instruction stream, and the live program counter, index, stack and accumulator values. The block then returns the address with a one-cycle valid pulse. It supports five address forms. Direct addressing places an 8-bit operand in a programmable page. Extended addressing uses a full 16-bit operand. Relative addressing adds a signed 8-bit or a 16-bit displacement to the program counter. Indexed addressing selects one of five base registers and adds a constant or an accumulator to it.

Any of these addresses can instead be treated as a pointer. In that case the block reads two bytes over a simple request/acknowledge memory port, most significant byte first. The pair it reads becomes the result. A start pulse is accepted only while the block is idle. Start requests that arrive while a pointer read is still in progress are dropped.

Top module: `eaGen`

## Requirements
- R1: Mode code 0 (direct) yields {page, opLo}. The page register resets to 00h and takes pageIn on a clock edge where pageWe is high. For example, writing 81h makes operand 00h address 8100h.
- R2: Mode code 1 (extended) yields {opHi, opLo}. Mode codes 5 to 7 behave the same as code 1.
- R3: Mode code 2 yields pc plus opLo sign-extended to 16 bits. Mode code 3 yields pc plus {opHi, opLo}. Both sums wrap modulo 65536.
- R4: Mode code 4 (indexed) takes its base from baseSel: 0 selects X, 1 Y, 2 U, 3 S and 4 PC. Codes 5 to 7 select X.
- R5: The indexed offset comes from offSel: 0 adds zero, 1 adds opLo sign-extended, 2 adds {opHi, opLo}, 3 adds accA sign-extended, 4 adds accB sign-extended and 5 adds {accA, accB}. Codes 6 and 7 add zero. The sum wraps modulo 65536.
- R6: When indirect is low, eaValid rises on the clock edge after the one that accepts start, and the block issues no memory request.
- R7: When indirect is high, the computed address P is read as a pointer. The block first reads P and then P+1, with wrap, and holds memReq and memAddr steady until memAck. The result is {byte at P, byte at P+1}. eaValid rises on the edge after the second acknowledge.
- R8: eaValid lasts exactly one cycle. eaOut keeps its value until the next result is produced.
- R9: A start that arrives while busy is high is ignored. It does not change the pending result and does not cause extra reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pageWe | input | 1 | Load strobe for the page register |
| pageIn | input | 8 | New page register value |
| start | input | 1 | Begin address generation; accepted only while idle |
| mode | input | 3 | Address form code |
| indirect | input | 1 | Treat the computed address as a pointer |
| baseSel | input | 3 | Indexed base register select |
| offSel | input | 3 | Indexed offset select |
| opHi | input | 8 | Operand high byte |
| opLo | input | 8 | Operand low byte |
| pc | input | 16 | Program counter |
| regX | input | 16 | Index register X |
| regY | input | 16 | Index register Y |
| regU | input | 16 | User stack pointer |
| regS | input | 16 | System stack pointer |
| accA | input | 8 | Accumulator A |
| accB | input | 8 | Accumulator B |
| memReq | output | 1 | Pointer read request |
| memAddr | output | 16 | Pointer read address |
| memAck | input | 1 | Read acknowledge; memData valid with it |
| memData | input | 8 | Read data |
| busy | output | 1 | An operation is in flight |
| eaValid | output | 1 | One-cycle result strobe |
| eaOut | output | 16 | Effective address |

## Verification
The bench targets the following corner cases:
- Offsets with bit 7 set (80h, FFh) in the relative and accumulator forms. A design that zero-extends them lands 256 bytes too high.
- Program counter values near FFFFh. A design that carries out of 16 bits, or mishandles the carry, returns a wrong address.
- A pointer stored at FFFFh. Its second byte must come from 0000h; a design without wrap reads the wrong location.
- A slow memory that withholds memAck. A design that does not wait for the acknowledge latches stale data, or announces the result after a single read.
- A second start issued in the middle of a pointer read. A design that re-arms would overwrite the pending result or issue a third read.

// File: rtl/eaPkg.sv
package eaPkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = ADDR_W / 2;

  localparam logic [2:0] MODE_DIR   = 3'd0;
  localparam logic [2:0] MODE_EXT   = 3'd1;
  localparam logic [2:0] MODE_REL8  = 3'd2;
  localparam logic [2:0] MODE_REL16 = 3'd3;
  localparam logic [2:0] MODE_IDX   = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_RDHI, ST_RDLO, ST_DONE} eaState_t;

  typedef struct packed {
    logic loadPtr;
    logic loadRes;
    logic capHi;
    logic capLo;
    logic ptrNext;
  } eaStrobe_t;
endpackage

// File: rtl/eaDatapath.sv
module eaDatapath
  import eaPkg::*;
#(
  parameter int AW = ADDR_W,
  localparam int BW = AW / 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  eaStrobe_t     strb,
  input  logic          pageWe,
  input  logic [BW-1:0] pageIn,
  input  logic [2:0]    mode,
  input  logic [2:0]    baseSel,
  input  logic [2:0]    offSel,
  input  logic [BW-1:0] opHi,
  input  logic [BW-1:0] opLo,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] regX,
  input  logic [AW-1:0] regY,
  input  logic [AW-1:0] regU,
  input  logic [AW-1:0] regS,
  input  logic [BW-1:0] accA,
  input  logic [BW-1:0] accB,
  input  logic [BW-1:0] memData,
  output logic [AW-1:0] memAddr,
  output logic [AW-1:0] eaOut
);
  logic [BW-1:0] pageReg, hiReg;
  logic [AW-1:0] ptrReg, resReg, baseVal, offVal, rawAddr, opWord;

  assign opWord = {opHi, opLo};

  // Index base selection
  always_comb begin
    case (baseSel)
      3'd1:    baseVal = regY;
      3'd2:    baseVal = regU;
      3'd3:    baseVal = regS;
      3'd4:    baseVal = pc;
      default: baseVal = regX;
    endcase
  end

  // Index offset selection, byte offsets sign-extended
  always_comb begin
    case (offSel)
      3'd1:    offVal = {{BW{opLo[BW-1]}}, opLo};
      3'd2:    offVal = opWord;
      3'd3:    offVal = {{BW{accA[BW-1]}}, accA};
      3'd4:    offVal = {{BW{accB[BW-1]}}, accB};
      3'd5:    offVal = {accA, accB};
      default: offVal = '0;
    endcase
  end

  always_comb begin
    case (mode)
      MODE_DIR:   rawAddr = {pageReg, opLo};
      MODE_REL8:  rawAddr = pc + {{BW{opLo[BW-1]}}, opLo};
      MODE_REL16: rawAddr = pc + opWord;
      MODE_IDX:   rawAddr = baseVal + offVal;
      default:    rawAddr = opWord;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg <= '0;
      hiReg   <= '0;
      ptrReg  <= '0;
      resReg  <= '0;
    end else begin
      if (pageWe)       pageReg <= pageIn;
      if (strb.loadPtr) ptrReg  <= rawAddr;
      if (strb.loadRes) resReg  <= rawAddr;
      if (strb.capHi)   hiReg   <= memData;
      if (strb.capLo)   resReg  <= {hiReg, memData};
    end
  end

  assign memAddr = strb.ptrNext ? ptrReg + AW'(1) : ptrReg;
  assign eaOut   = resReg;
endmodule

// File: rtl/eaControl.sv
module eaControl
  import eaPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      indirect,
  input  logic      memAck,
  output eaStrobe_t strb,
  output logic      memReq,
  output logic      eaValid,
  output logic      busy
);
  eaState_t state, stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      ST_IDLE: if (start) begin
        strb.loadPtr = 1'b1;
        strb.loadRes = !indirect;
        stateNext    = indirect ? ST_RDHI : ST_DONE;
      end
      ST_RDHI: if (memAck) begin
        strb.capHi = 1'b1;
        stateNext  = ST_RDLO;
      end
      ST_RDLO: begin
        strb.ptrNext = 1'b1;
        if (memAck) begin
          strb.capLo = 1'b1;
          stateNext  = ST_DONE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign memReq  = (state == ST_RDHI) || (state == ST_RDLO);
  assign eaValid = (state == ST_DONE);
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/eaGen.sv
module eaGen
  import eaPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pageWe,
  input  logic [7:0]  pageIn,
  input  logic        start,
  input  logic [2:0]  mode,
  input  logic        indirect,
  input  logic [2:0]  baseSel,
  input  logic [2:0]  offSel,
  input  logic [7:0]  opHi,
  input  logic [7:0]  opLo,
  input  logic [15:0] pc,
  input  logic [15:0] regX,
  input  logic [15:0] regY,
  input  logic [15:0] regU,
  input  logic [15:0] regS,
  input  logic [7:0]  accA,
  input  logic [7:0]  accB,
  output logic        memReq,
  output logic [15:0] memAddr,
  input  logic        memAck,
  input  logic [7:0]  memData,
  output logic        busy,
  output logic        eaValid,
  output logic [15:0] eaOut
);
  eaStrobe_t strb;

  eaControl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .indirect(indirect),
    .memAck(memAck), .strb(strb), .memReq(memReq),
    .eaValid(eaValid), .busy(busy)
  );

  eaDatapath #(.AW(ADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .pageWe(pageWe), .pageIn(pageIn),
    .mode(mode), .baseSel(baseSel), .offSel(offSel), .opHi(opHi), .opLo(opLo),
    .pc(pc), .regX(regX), .regY(regY), .regU(regU), .regS(regS),
    .accA(accA), .accB(accB), .memData(memData), .memAddr(memAddr),
    .eaOut(eaOut)
  );
endmodule

// File: rtl/eaGenChecker.sv
module eaGenChecker (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        indirect,
  input logic        busy,
  input logic        memReq,
  input logic        memAck,
  input logic [15:0] memAddr,
  input logic        eaValid,
  input logic [15:0] eaOut
);
  logic       indSeen;
  logic [1:0] ackCnt;
  logic       lowPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      indSeen  <= 1'b0;
      ackCnt   <= '0;
      lowPhase <= 1'b0;
    end else begin
      if (start && !busy) begin
        indSeen  <= indirect;
        ackCnt   <= '0;
        lowPhase <= 1'b0;
      end else if (memReq && memAck) begin
        ackCnt   <= ackCnt + 2'd1;
        lowPhase <= !lowPhase;
      end
    end
  end

  // R6: plain address is announced on the next edge
  p_direct_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && !indirect |=> eaValid);

  // R6: no memory traffic while idle
  p_no_req_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

  // R7: request and address held until acknowledged
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr));

  // R7: second read follows at pointer plus one
  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck && !lowPhase |=> memReq && (memAddr == $past(memAddr) + 16'd1));

  // R7: result only after exactly the required reads
  p_ack_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    eaValid |-> (ackCnt == (indSeen ? 2'd2 : 2'd0)));

  // R8: single-cycle strobe, result held afterwards
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    eaValid |=> !eaValid && $stable(eaOut));
endmodule

bind eaGen eaGenChecker uChk (
  .clk(clk), .rstN(rstN), .start(start), .indirect(indirect), .busy(busy),
  .memReq(memReq), .memAck(memAck), .memAddr(memAddr), .eaValid(eaValid),
  .eaOut(eaOut)
);

// File: tb/tb_eaGen.sv
`timescale 1ns/1ps
module tb_eaGen;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        pageWe = 1'b0, start = 1'b0, indirect = 1'b0;
  logic [7:0]  pageIn = '0, opHi = '0, opLo = '0, accA = '0, accB = '0;
  logic [2:0]  mode = '0, baseSel = '0, offSel = '0;
  logic [15:0] pc = '0, regX = '0, regY = '0, regU = '0, regS = '0;
  logic        memReq, memAck = 1'b0, busy, eaValid;
  logic [7:0]  memData = '0;
  logic [15:0] memAddr, eaOut;

  int checks = 0, errors = 0;
  logic [7:0]  pageMirror = '0;
  logic        slowAck = 1'b0, tick = 1'b0;
  int          logN = 0;
  logic [15:0] logA [4];

  always #2.5 clk = ~clk;

  eaGen dut (.*);

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[15:8] ^ {a[6:0], a[7]} ^ 8'hA5;
  endfunction

  // Memory model: answers at the falling edge, optionally every other cycle
  always @(negedge clk) begin
    tick = ~tick;
    if (memReq && (!slowAck || tick)) begin
      memAck  = 1'b1;
      memData = memByte(memAddr);
      if (logN < 4) logA[logN] = memAddr;
      logN++;
    end else begin
      memAck  = 1'b0;
      memData = 8'h00;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sx(input logic [7:0] v);
    return {{8{v[7]}}, v};
  endfunction

  function automatic logic [15:0] expAddr(input logic [2:0] md, input logic [2:0] bs,
                                          input logic [2:0] os);
    logic [15:0] b, o;
    case (bs)
      3'd1: b = regY; 3'd2: b = regU; 3'd3: b = regS; 3'd4: b = pc;
      default: b = regX;
    endcase
    case (os)
      3'd1: o = sx(opLo); 3'd2: o = {opHi, opLo}; 3'd3: o = sx(accA);
      3'd4: o = sx(accB); 3'd5: o = {accA, accB};
      default: o = 16'h0;
    endcase
    case (md)
      3'd0: return {pageMirror, opLo};
      3'd2: return pc + sx(opLo);
      3'd3: return pc + {opHi, opLo};
      3'd4: return b + o;
      default: return {opHi, opLo};
    endcase
  endfunction

  task automatic setPage(input logic [7:0] v);
    @(negedge clk); pageWe = 1'b1; pageIn = v;
    @(negedge clk); pageWe = 1'b0;
    pageMirror = v;
  endtask

  task automatic runOp(input string req, input logic [2:0] md, input logic ind,
                       input logic [2:0] bs, input logic [2:0] os, input logic [7:0] hi,
                       input logic [7:0] lo, input logic intrude);
    int cyc;
    logic [15:0] p, e;
    @(negedge clk);
    mode = md; indirect = ind; baseSel = bs; offSel = os; opHi = hi; opLo = lo;
    start = 1'b1; logN = 0;
    p = expAddr(md, bs, os);
    @(negedge clk);
    start = 1'b0; cyc = 1;
    if (intrude) begin
      // R9: foreign request while busy, different operands
      mode = 3'd1; indirect = 1'b0; opHi = ~hi; opLo = ~lo; start = 1'b1;
      @(negedge clk); start = 1'b0; cyc++;
    end
    while (!eaValid && cyc < 60) begin @(negedge clk); cyc++; end
    if (ind) begin
      e = {memByte(p), memByte(p + 16'd1)};
      chk({req, "/R7 reads"}, 16'(logN), 16'd2);
      chk({req, "/R7 hi addr"}, logA[0], p);
      chk({req, "/R7 lo addr"}, logA[1], p + 16'd1);
    end else begin
      e = p;
      chk({req, "/R6 latency"}, 16'(cyc), 16'd1);
      chk({req, "/R6 no read"}, 16'(logN), 16'd0);
    end
    chk({req, " valid"}, 16'(eaValid), 16'd1);
    chk({req, " addr"}, eaOut, e);
    @(negedge clk);
    chk("R8 pulse", 16'(eaValid), 16'd0);
    chk("R8 hold", eaOut, e);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R6 reset valid", 16'(eaValid), 16'd0);
    chk("R6 reset busy", 16'(busy), 16'd0);
    chk("R6 reset req", 16'(memReq), 16'd0);

    // R1: page register reset value then sweep
    runOp("R1", 3'd0, 1'b0, 3'd0, 3'd0, 8'h12, 8'h34, 1'b0);
    setPage(8'h81);
    runOp("R1", 3'd0, 1'b0, 3'd0, 3'd0, 8'h00, 8'h00, 1'b0);
    for (int pg = 0; pg < 256; pg += 17) begin
      setPage(8'(pg));
      for (int lo = 0; lo < 256; lo += 51)
        runOp("R1", 3'd0, 1'b0, 3'd0, 3'd0, 8'h5A, 8'(lo), 1'b0);
    end

    // R2: extended and spare mode codes
    for (int m = 1; m < 8; m++) begin
      if (m >= 2 && m <= 4) continue;
      for (int v = 0; v < 65536; v += 4111)
        runOp("R2", 3'(m), 1'b0, 3'd0, 3'd0, 8'(v >> 8), 8'(v), 1'b0);
    end

    // R3: relative, sign and wrap corners
    for (int pi = 0; pi < 5; pi++) begin
      case (pi)
        0: pc = 16'h0000; 1: pc = 16'h0010; 2: pc = 16'hFFF0;
        3: pc = 16'h8000; default: pc = 16'h7FFF;
      endcase
      for (int o = 0; o < 256; o += 15) begin
        runOp("R3", 3'd2, 1'b0, 3'd0, 3'd0, 8'h00, 8'(o), 1'b0);
        runOp("R3", 3'd3, 1'b0, 3'd0, 3'd0, 8'(o ^ 8'hC3), 8'(o), 1'b0);
      end
      runOp("R3", 3'd2, 1'b0, 3'd0, 3'd0, 8'h00, 8'hFF, 1'b0);
      runOp("R3", 3'd2, 1'b0, 3'd0, 3'd0, 8'h00, 8'h80, 1'b0);
    end

    // R4/R5: every base with every offset source
    regX = 16'h1000; regY = 16'h2345; regU = 16'hFFFE; regS = 16'h8001; pc = 16'hC00F;
    for (int av = 0; av < 3; av++) begin
      case (av)
        0: begin accA = 8'h7F; accB = 8'h80; end
        1: begin accA = 8'hFF; accB = 8'h01; end
        default: begin accA = 8'h80; accB = 8'hFF; end
      endcase
      for (int b = 0; b < 8; b++)
        for (int o = 0; o < 8; o++) begin
          runOp("R4", 3'd4, 1'b0, 3'(b), 3'(o), 8'hF0, 8'h90, 1'b0);
          runOp("R5", 3'd4, 1'b0, 3'(b), 3'(o), 8'h01, 8'h7E, 1'b0);
        end
    end

    // R7: pointer reads in every mode, fast and slow memory, wrap at top
    setPage(8'hFF);
    pc = 16'hFFFE;
    for (int sl = 0; sl < 2; sl++) begin
      slowAck = sl[0];
      runOp("R7", 3'd0, 1'b1, 3'd0, 3'd0, 8'h00, 8'hFF, 1'b0);
      runOp("R7", 3'd1, 1'b1, 3'd0, 3'd0, 8'hFF, 8'hFF, 1'b0);
      runOp("R7", 3'd1, 1'b1, 3'd0, 3'd0, 8'h12, 8'h34, 1'b0);
      runOp("R7", 3'd2, 1'b1, 3'd0, 3'd0, 8'h00, 8'h01, 1'b0);
      runOp("R7", 3'd3, 1'b1, 3'd0, 3'd0, 8'h10, 8'h02, 1'b0);
      runOp("R7", 3'd4, 1'b1, 3'd2, 3'd5, 8'h00, 8'h00, 1'b0);
      runOp("R7", 3'd4, 1'b1, 3'd3, 3'd3, 8'h00, 8'h00, 1'b0);
    end

    // R9: start while busy must be dropped
    slowAck = 1'b1;
    runOp("R9", 3'd1, 1'b1, 3'd0, 3'd0, 8'hAB, 8'hCD, 1'b1);
    runOp("R9", 3'd4, 1'b1, 3'd1, 3'd2, 8'h00, 8'h40, 1'b1);
    slowAck = 1'b0;
    runOp("R9", 3'd3, 1'b1, 3'd0, 3'd0, 8'h00, 8'h03, 1'b1);

    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule